// File: doc/BRIEF.md
# Dual-Lane Correlator Multiply-Accumulate Cell

This cell does the cross-multiply work for one baseline in an FX correlator. The spectra it receives come from real-sampled antennas. In each cycle it takes one 16-bit complex spectral sample from antenna A and one from antenna B, both for the same frequency channel k. It accumulates the visibility product for that channel. In the same cycle it also accumulates the product for the mirror channel N-k.

A real-valued input gives a spectrum in which the bin at N-k is the complex conjugate of the bin at k. Because of this, the mirror-channel product can be formed from the operands already on hand, with no extra input bandwidth. Lane 0 forms A·conj(B). Lane 1 forms conj(A)·B, which is the product at channel N-k. Each lane has its own four signed multipliers, so one cell does the work of two conventional complex multiply-accumulators.

Integration periods can close in two ways. A caller can send an explicit dump strobe, or the cell can close a period itself after a runtime-programmable number of valid samples. When a period closes, both lane sums appear on the output with a one-cycle valid strobe. The next period starts at once, so no sample is dropped.

Top module: `xcell_dual_cmac`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and all four visibility outputs are 0. Samples and dumps presented during reset are never accumulated and never produce an output.
- R2: Lane 0 accumulates A·conj(B) for each valid sample. The real part adds a_re·b_re + a_im·b_im, and the imaginary part adds a_im·b_re − a_re·b_im. All operands are signed two's complement 16-bit values.
- R3: Lane 1 accumulates conj(A)·B, the mirror-channel product. Its real sum equals the lane 0 real sum, and its imaginary sum is the negated lane 0 imaginary sum.
- R4: A period that closes on inputs presented before rising edge n sets `out_valid` high after edge n+3, for exactly one cycle.
- R5: A `in_dump` strobe closes the period without the sample of its own cycle. The output holds the sum of the valid samples taken since the previous close. If that dump-cycle sample is valid, it becomes the first sample of the new period. A dump with `in_valid` low closes the period and leaves it empty.
- R6: When `int_len` is between 1 and 16384, a period also closes on the valid sample that brings the count since the last close up to `int_len`, and that sample is part of the closing sum. When `int_len` is 0, automatic closing is off.
- R7: If a dump and an automatic close fall in the same cycle, the dump wins. The sample of that cycle counts as the first sample of the new period.
- R8: Each accumulator is 48 bits wide and wraps modulo 2^48 with no saturation.
- R9: Data presented while `in_valid` is low is not accumulated.
- R10: Between closes, the visibility outputs hold the sums of the last closed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on a_*/b_* is valid this cycle |
| in_dump | input | 1 | Close the current period before this cycle's sample |
| int_len | input | 15 | Samples per automatic period, 0 disables |
| a_re | input | 16 | Antenna A spectral sample, real part |
| a_im | input | 16 | Antenna A spectral sample, imaginary part |
| b_re | input | 16 | Antenna B spectral sample, real part |
| b_im | input | 16 | Antenna B spectral sample, imaginary part |
| out_valid | output | 1 | One-cycle strobe: the visibilities below are new |
| vis0_re | output | 48 | Lane 0 (channel k) visibility, real part |
| vis0_im | output | 48 | Lane 0 visibility, imaginary part |
| vis1_re | output | 48 | Lane 1 (channel N-k) visibility, real part |
| vis1_im | output | 48 | Lane 1 visibility, imaginary part |

## Verification
Two closing events can land in the same cycle. One is a dump strobe. The other is the automatic close reached when the sample count hits `int_len`. The bench provokes this with `int_len` set to 2. It sends one valid sample, then a valid sample carrying a dump. The first output must hold only the first sample, and the next output must appear one sample later and hold the second and third samples. Separately, a dump arriving together with a valid sample is checked to carry that sample into the next period and not to drop it.

// File: rtl/xcell_pkg.sv
package xcell_pkg;

   // Control tag that travels beside the datapath, one per pipeline stage.
   typedef struct packed {
      logic valid;   // the operands in this stage belong to a real sample
      logic dump;    // close the period before this sample
      logic last;    // close the period including this sample
   } xc_tag_t;

   // Register stages between the input pins and the accumulators.
   localparam int XC_PIPE_STAGES = 3;

endpackage

// File: rtl/xcell_int_ctrl.sv
module xcell_int_ctrl
   import xcell_pkg::*;
#(
   parameter int LEN_W = 15
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_dump,
   input  logic [LEN_W-1:0] int_len,
   output xc_tag_t          tag_d
);

   localparam logic [LEN_W:0]   ONE_X = (LEN_W+1)'(1);
   localparam logic [LEN_W-1:0] ONE_C = LEN_W'(1);

   logic [LEN_W-1:0] cnt_q, cnt_d;
   logic             auto_on;
   logic             reach;

   assign auto_on = (int_len != '0);
   assign reach   = (({1'b0, cnt_q} + ONE_X) >= {1'b0, int_len});

   always_comb begin
      tag_d.valid = in_valid;
      tag_d.dump  = in_dump;
      tag_d.last  = in_valid && !in_dump && auto_on && reach;
   end

   always_comb begin
      cnt_d = cnt_q;
      if (in_dump) begin
         cnt_d = in_valid ? ONE_C : '0;
      end else if (!auto_on) begin
         cnt_d = '0;
      end else if (in_valid) begin
         cnt_d = reach ? '0 : (cnt_q + ONE_C);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
      ($stable(int_len) && int_len != '0 && $past(cnt_q) <= int_len) |-> cnt_q <= int_len) // R6
      else $error("count ran past the integration length");

   AST_DUMP_RESTART: assert property (@(posedge clk) disable iff (rst)
      in_dump |=> cnt_q <= ONE_C) // R7
      else $error("dump did not restart the sample count");

endmodule

// File: rtl/xcell_cmult.sv
module xcell_cmult #(
   parameter int DATA_W = 16,
   parameter bit MIRROR = 1'b0,
   localparam int PROD_W = 2 * DATA_W,
   localparam int SUM_W  = PROD_W + 1
) (
   input  logic                     clk,
   input  logic signed [DATA_W-1:0] a_re,
   input  logic signed [DATA_W-1:0] a_im,
   input  logic signed [DATA_W-1:0] b_re,
   input  logic signed [DATA_W-1:0] b_im,
   output logic signed [SUM_W-1:0]  p_re,
   output logic signed [SUM_W-1:0]  p_im
);

   // Stage: four partial products.
   logic signed [PROD_W-1:0] rr_q, ii_q, ir_q, ri_q;

   always_ff @(posedge clk) begin
      rr_q <= a_re * b_re;
      ii_q <= a_im * b_im;
      ir_q <= a_im * b_re;
      ri_q <= a_re * b_im;
   end

   logic signed [SUM_W-1:0] rr_x, ii_x, ir_x, ri_x;
   assign rr_x = {rr_q[PROD_W-1], rr_q};
   assign ii_x = {ii_q[PROD_W-1], ii_q};
   assign ir_x = {ir_q[PROD_W-1], ir_q};
   assign ri_x = {ri_q[PROD_W-1], ri_q};

   logic signed [SUM_W-1:0] im_d;

   generate
      if (MIRROR) begin : g_conj_a
         // conj(A) * B
         assign im_d = ri_x - ir_x;
      end else begin : g_conj_b
         // A * conj(B)
         assign im_d = ir_x - ri_x;
      end
   endgenerate

   // Stage: combined real and imaginary parts.
   always_ff @(posedge clk) begin
      p_re <= rr_x + ii_x;
      p_im <= im_d;
   end

endmodule

// File: rtl/xcell_lane_acc.sv
module xcell_lane_acc
   import xcell_pkg::*;
#(
   parameter int SUM_W = 33,
   parameter int ACC_W = 48
) (
   input  logic                    clk,
   input  logic                    rst,
   input  xc_tag_t                 tag,
   input  logic signed [SUM_W-1:0] p_re,
   input  logic signed [SUM_W-1:0] p_im,
   output logic signed [ACC_W-1:0] vis_re,
   output logic signed [ACC_W-1:0] vis_im
);

   localparam int EXT_W = ACC_W - SUM_W;

   logic signed [ACC_W-1:0] acc_re, acc_im;
   logic signed [ACC_W-1:0] px_re, px_im;

   assign px_re = {{EXT_W{p_re[SUM_W-1]}}, p_re};
   assign px_im = {{EXT_W{p_im[SUM_W-1]}}, p_im};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_re <= '0;
         acc_im <= '0;
         vis_re <= '0;
         vis_im <= '0;
      end else if (tag.dump) begin
         vis_re <= acc_re;
         vis_im <= acc_im;
         acc_re <= tag.valid ? px_re : '0;
         acc_im <= tag.valid ? px_im : '0;
      end else if (tag.valid && tag.last) begin
         vis_re <= acc_re + px_re;
         vis_im <= acc_im + px_im;
         acc_re <= '0;
         acc_im <= '0;
      end else if (tag.valid) begin
         acc_re <= acc_re + px_re;
         acc_im <= acc_im + px_im;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!tag.valid && !tag.dump) |=> ($stable(acc_re) && $stable(acc_im))) // R9
      else $error("accumulator moved without a valid sample");

   AST_VIS_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(tag.dump || tag.last) |=> ($stable(vis_re) && $stable(vis_im))) // R10
      else $error("visibility changed without a close");

   AST_EMPTY_DUMP: assert property (@(posedge clk) disable iff (rst)
      (tag.dump && !tag.valid) |=> (acc_re == '0 && acc_im == '0)) // R5
      else $error("empty dump left a residue in the accumulator");

endmodule

// File: rtl/xcell_dual_cmac.sv
module xcell_dual_cmac
   import xcell_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ACC_W        = 48,
   parameter int MAX_INT      = 16384,
   parameter bit LANE1_SHARED = 1'b0,
   localparam int SUM_W       = 2 * DATA_W + 1,
   localparam int LEN_W       = $clog2(MAX_INT) + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic                     in_dump,
   input  logic [LEN_W-1:0]         int_len,
   input  logic signed [DATA_W-1:0] a_re,
   input  logic signed [DATA_W-1:0] a_im,
   input  logic signed [DATA_W-1:0] b_re,
   input  logic signed [DATA_W-1:0] b_im,
   output logic                     out_valid,
   output logic signed [ACC_W-1:0]  vis0_re,
   output logic signed [ACC_W-1:0]  vis0_im,
   output logic signed [ACC_W-1:0]  vis1_re,
   output logic signed [ACC_W-1:0]  vis1_im
);

   localparam int PIPE_N = XC_PIPE_STAGES;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 2) begin : g_chk_data
         $error("DATA_W must be at least 2");
      end
      if (ACC_W < SUM_W + 1) begin : g_chk_acc
         $error("ACC_W must exceed the product sum width");
      end
      if (MAX_INT < 1) begin : g_chk_len
         $error("MAX_INT must be at least 1");
      end
   endgenerate

   // Integration control and tag pipeline.
   xc_tag_t tag_d;
   xc_tag_t tag_q [PIPE_N];

   xcell_int_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_dump  (in_dump),
      .int_len  (int_len),
      .tag_d    (tag_d)
   );

   generate
      for (genvar s = 0; s < PIPE_N; s++) begin : g_tag
         always_ff @(posedge clk) begin
            if (rst)         tag_q[s] <= '0;
            else if (s == 0) tag_q[s] <= tag_d;
            else             tag_q[s] <= tag_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   // Operand register stage.
   logic signed [DATA_W-1:0] ar_q, ai_q, br_q, bi_q;

   always_ff @(posedge clk) begin
      ar_q <= a_re;
      ai_q <= a_im;
      br_q <= b_re;
      bi_q <= b_im;
   end

   // Lane 0 multiplier: A * conj(B).
   logic signed [SUM_W-1:0] l0_re, l0_im, l1_re, l1_im;

   xcell_cmult #(.DATA_W(DATA_W), .MIRROR(1'b0)) u_mul0 (
      .clk  (clk),
      .a_re (ar_q),
      .a_im (ai_q),
      .b_re (br_q),
      .b_im (bi_q),
      .p_re (l0_re),
      .p_im (l0_im)
   );

   // Lane 1: mirror channel, conj(A) * B.
   generate
      if (LANE1_SHARED) begin : g_l1_shared
         assign l1_re = l0_re;
         assign l1_im = -l0_im;
      end else begin : g_l1_own
         xcell_cmult #(.DATA_W(DATA_W), .MIRROR(1'b1)) u_mul1 (
            .clk  (clk),
            .a_re (ar_q),
            .a_im (ai_q),
            .b_re (br_q),
            .b_im (bi_q),
            .p_re (l1_re),
            .p_im (l1_im)
         );

         AST_MIRROR_RE: assert property (@(posedge clk) disable iff (rst)
            tag_q[PIPE_N-1].valid |-> (l1_re == l0_re)) // R3
            else $error("mirror lane real part differs");

         AST_MIRROR_IM: assert property (@(posedge clk) disable iff (rst)
            tag_q[PIPE_N-1].valid |-> (l1_im == -l0_im)) // R3
            else $error("mirror lane imaginary part is not conjugate");
      end
   endgenerate

   // Accumulators.
   xcell_lane_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc0 (
      .clk    (clk),
      .rst    (rst),
      .tag    (tag_q[PIPE_N-1]),
      .p_re   (l0_re),
      .p_im   (l0_im),
      .vis_re (vis0_re),
      .vis_im (vis0_im)
   );

   xcell_lane_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc1 (
      .clk    (clk),
      .rst    (rst),
      .tag    (tag_q[PIPE_N-1]),
      .p_re   (l1_re),
      .p_im   (l1_im),
      .vis_re (vis1_re),
      .vis_im (vis1_im)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= tag_q[PIPE_N-1].dump | tag_q[PIPE_N-1].last;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !out_valid) // R1
      else $error("out_valid raised out of reset");

   AST_CLOSE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(tag_q[0].dump || tag_q[0].last, 3)) // R4
      else $error("out_valid without a close three stages earlier");

endmodule

// File: tb/sim_xcell_dual_cmac.sv
`timescale 1ns/1ps
module sim_xcell_dual_cmac;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_dump = 1'b0;
   logic [14:0] int_len = '0;
   logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
   logic out_valid;
   logic signed [47:0] vis0_re, vis0_im, vis1_re, vis1_im;

   always #2.5 clk = ~clk;

   xcell_dual_cmac u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_dump(in_dump),
      .int_len(int_len), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
      .out_valid(out_valid), .vis0_re(vis0_re), .vis0_im(vis0_im),
      .vis1_re(vis1_re), .vis1_im(vis1_im)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Output capture.
   logic [47:0] c0r [64];
   logic [47:0] c0i [64];
   logic [47:0] c1r [64];
   logic [47:0] c1i [64];
   int cap_n = 0;

   always @(negedge clk) begin
      if (out_valid === 1'b1 && cap_n < 64) begin
         c0r[cap_n] = vis0_re;
         c0i[cap_n] = vis0_im;
         c1r[cap_n] = vis1_re;
         c1i[cap_n] = vis1_im;
         cap_n = cap_n + 1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic longint pre(int ar, int ai, int br, int bi);
      return longint'(ar) * longint'(br) + longint'(ai) * longint'(bi);
   endfunction

   function automatic longint pim(int ar, int ai, int br, int bi);
      return longint'(ai) * longint'(br) - longint'(ar) * longint'(bi);
   endfunction

   task automatic put(input int ar, input int ai, input int br, input int bi,
                      input bit v, input bit d);
      @(negedge clk);
      a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
      in_valid = v; in_dump = d;
   endtask

   task automatic flush(input int n);
      for (int i = 0; i < n; i++) put(0, 0, 0, 0, 1'b0, 1'b0);
      #1;
   endtask

   task automatic chk_close(input string req, input int idx, input longint er, input longint ei);
      chk(req, "lane0 re", c0r[idx], 48'(er));
      chk(req, "lane0 im", c0i[idx], 48'(ei));
      chk(req, "lane1 re", c1r[idx], 48'(er));
      chk(req, "lane1 im", c1i[idx], 48'(-ei));
   endtask

   // R1: reset quiet, samples under reset ignored
   task automatic t_reset();
      for (int i = 0; i < 4; i++) put(1000, -2000, 3000, 400, 1'b1, 1'b1);
      #1;
      chk("R1", "out_valid in reset", 48'(out_valid), 48'd0);
      chk("R1", "vis0_re in reset", vis0_re, 48'd0);
      chk("R1", "vis1_im in reset", vis1_im, 48'd0);
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0; in_dump = 1'b0;
      flush(6);
      chk("R1", "closes after reset", 48'(cap_n), 48'd0);
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
      chk("R1", "closes after first dump", 48'(cap_n), 48'd1);
      chk_close("R1", 0, 0, 0);
   endtask

   // R2 R3 R6(off): plain accumulation, int_len 0
   task automatic t_basic();
      int base = cap_n;
      longint er = 0, ei = 0;
      int sa [5][4] = '{'{3, 4, 5, -6}, '{-100, 200, 7, 9},
                        '{32767, -32768, -32768, 32767}, '{0, 1, 1, 0},
                        '{-1234, 5678, 2222, -3333}};
      foreach (sa[i]) begin
         put(sa[i][0], sa[i][1], sa[i][2], sa[i][3], 1'b1, 1'b0);
         er += pre(sa[i][0], sa[i][1], sa[i][2], sa[i][3]);
         ei += pim(sa[i][0], sa[i][1], sa[i][2], sa[i][3]);
      end
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
      chk("R6", "no auto close with int_len 0", 48'(cap_n), 48'(base + 1));
      chk_close("R2", base, er, ei);
      chk("R3", "mirror im is negated", c1i[base], 48'(-ei));
   endtask

   // R4: close latency and one-cycle strobe
   task automatic t_latency();
      int base = cap_n;
      put(11, -22, 33, 44, 1'b1, 1'b0);
      put(0, 0, 0, 0, 1'b0, 1'b1);
      put(0, 0, 0, 0, 1'b0, 1'b0);
      chk("R4", "valid after edge n", 48'(out_valid), 48'd0);
      put(0, 0, 0, 0, 1'b0, 1'b0);
      chk("R4", "valid after edge n+1", 48'(out_valid), 48'd0);
      put(0, 0, 0, 0, 1'b0, 1'b0);
      chk("R4", "valid after edge n+2", 48'(out_valid), 48'd0);
      put(0, 0, 0, 0, 1'b0, 1'b0);
      chk("R4", "valid after edge n+3", 48'(out_valid), 48'd1);
      put(0, 0, 0, 0, 1'b0, 1'b0);
      chk("R4", "valid after edge n+4", 48'(out_valid), 48'd0);
      #1;
      chk_close("R4", base, pre(11, -22, 33, 44), pim(11, -22, 33, 44));
   endtask

   // R9: invalid cycles carry garbage that must not count
   task automatic t_gaps();
      int base = cap_n;
      put(500, 600, 700, 800, 1'b1, 1'b0);
      put(32767, 32767, -32768, -32768, 1'b0, 1'b0);
      put(-9, 8, -7, 6, 1'b1, 1'b0);
      put(-32768, 12345, 32767, -1, 1'b0, 1'b0);
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
      chk_close("R9", base, pre(500, 600, 700, 800) + pre(-9, 8, -7, 6),
                pim(500, 600, 700, 800) + pim(-9, 8, -7, 6));
   endtask

   // R5: dump with a valid sample carries it into the next period
   task automatic t_carry();
      int base = cap_n;
      put(1, 2, 3, 4, 1'b1, 1'b0);
      put(5, 6, 7, 8, 1'b1, 1'b0);
      put(-10, 20, 30, -40, 1'b1, 1'b1);
      put(100, 0, 0, 100, 1'b1, 1'b0);
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
      chk("R5", "two closes", 48'(cap_n), 48'(base + 2));
      chk_close("R5", base, pre(1, 2, 3, 4) + pre(5, 6, 7, 8),
                pim(1, 2, 3, 4) + pim(5, 6, 7, 8));
      chk_close("R5", base + 1, pre(-10, 20, 30, -40) + pre(100, 0, 0, 100),
                pim(-10, 20, 30, -40) + pim(100, 0, 0, 100));
   endtask

   // R6: automatic close every int_len valid samples
   task automatic t_auto();
      int base;
      @(negedge clk); int_len = 15'd3;
      flush(1);
      base = cap_n;
      for (int i = 1; i <= 7; i++) begin
         put(i, -i, 2 * i, 3, 1'b1, 1'b0);
         if (i % 2 == 0) put(999, 999, 999, 999, 1'b0, 1'b0);
      end
      flush(6);
      chk("R6", "auto closes", 48'(cap_n), 48'(base + 2));
      chk_close("R6", base, pre(1, -1, 2, 3) + pre(2, -2, 4, 3) + pre(3, -3, 6, 3),
                pim(1, -1, 2, 3) + pim(2, -2, 4, 3) + pim(3, -3, 6, 3));
      chk_close("R6", base + 1, pre(4, -4, 8, 3) + pre(5, -5, 10, 3) + pre(6, -6, 12, 3),
                pim(4, -4, 8, 3) + pim(5, -5, 10, 3) + pim(6, -6, 12, 3));
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
      chk_close("R6", base + 2, pre(7, -7, 14, 3), pim(7, -7, 14, 3));
   endtask

   // R7: dump and auto close in the same cycle
   task automatic t_prio();
      int base;
      @(negedge clk); int_len = 15'd2;
      flush(1);
      base = cap_n;
      put(10, 1, 2, 3, 1'b1, 1'b0);
      put(20, 4, 5, 6, 1'b1, 1'b1);
      put(30, 7, 8, 9, 1'b1, 1'b0);
      put(40, 1, 1, 1, 1'b1, 1'b0);
      put(50, 2, 2, 2, 1'b1, 1'b0);
      flush(6);
      chk("R7", "closes", 48'(cap_n), 48'(base + 3));
      chk_close("R7", base, pre(10, 1, 2, 3), pim(10, 1, 2, 3));
      chk_close("R7", base + 1, pre(20, 4, 5, 6) + pre(30, 7, 8, 9),
                pim(20, 4, 5, 6) + pim(30, 7, 8, 9));
      chk_close("R7", base + 2, pre(40, 1, 1, 1) + pre(50, 2, 2, 2),
                pim(40, 1, 1, 1) + pim(50, 2, 2, 2));
   endtask

   // R10: outputs hold between closes
   task automatic t_hold();
      int last = cap_n - 1;
      put(77, 77, 77, 77, 1'b1, 1'b0);
      for (int i = 0; i < 6; i++) begin
         put(-5, 5, -5, 5, 1'b0, 1'b0);
         chk("R10", "out_valid idle", 48'(out_valid), 48'd0);
         chk("R10", "vis0_re held", vis0_re, c0r[last]);
         chk("R10", "vis1_im held", vis1_im, c1i[last]);
      end
      @(negedge clk); int_len = 15'd0;
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
   endtask

   // R8: 48-bit wrap
   task automatic t_wrap();
      int base = cap_n;
      for (int i = 0; i < 65536; i++) put(-32768, -32768, -32768, -32768, 1'b1, 1'b0);
      put(0, 0, 0, 0, 1'b0, 1'b1);
      flush(6);
      chk("R8", "lane0 re wrapped", c0r[base], 48'h8000_0000_0000);
      chk("R8", "lane1 re wrapped", c1r[base], 48'h8000_0000_0000);
      chk("R8", "lane0 im", c0i[base], 48'd0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_latency();
      t_gaps();
      t_carry();
      t_auto();
      t_prio();
      t_hold();
      t_wrap();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual run still busy, expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule